// File: doc/BRIEF.md
# Decimal Floating-Point Data-Group Classifier

This unit inspects one decimal floating-point operand in the densely packed interchange encoding and reports whether it falls into any of the data groups chosen by a 6-bit mask. The operand width is fixed at compile time: 64 bits for the double format, 128 bits for the quad format. The unit unpacks the combination field and decodes every 10-bit declet into three BCD digits. From the decoded coefficient it counts the significant digits. With that count and the biased exponent it places the operand in exactly one group.

The answer is a 4-bit condition code carrying the operand sign and the match outcome. The same code is driven onto a floating-point condition-code output. A single-cycle `valid_i` pulse starts a classification. The code is registered on that edge and a `valid_o` pulse comes with it one cycle later. Between pulses the last code is held.

All exponent limits below are for the default 64-bit format (bias 398, biased exponent 0..767, 16 digits). The 128-bit format uses bias 6176, biased exponent 0..12287 and 34 digits.

Top module: `dfp_data_group_classifier`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `fpcc_o` read 4'b0000 and `valid_o` is 0.
- R2: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. `result_o` changes only on that edge and holds its value while `valid_i` is low.
- R3: The code is {sign, 0, match, 0}. A negative operand gives 4'b1010 when it matches and 4'b1000 when it does not. A positive operand gives 4'b0010 or 4'b0000. The sign is operand bit W-1 and applies to infinities and NaNs as well.
- R4: `fpcc_o` always equals `result_o`.
- R5: Mask bit 5 matches a zero coefficient whose biased exponent is neither 0 nor the maximum (767).
- R6: Mask bit 4 matches a zero coefficient whose biased exponent is 0 (exponent -398) or 767 (exponent 369).
- R7: Mask bit 3 matches two kinds of operand. The first is a subnormal: a nonzero finite operand with exponent + digits - 1 < -383, which is the same as biased exponent + digit count < 16. The second is a normal operand whose biased exponent is 0 or 767.
- R8: Mask bit 2 matches a normal operand at a non-extreme exponent whose leading digit (coefficient digit 15) is zero.
- R9: Mask bit 1 matches a normal operand at a non-extreme exponent whose leading digit is nonzero.
- R10: Mask bit 0 matches infinity (combination field 5'b11110) and NaN (5'b11111), whatever the other bits hold. Special values never match bits 5..1.
- R11: The digit count is the index of the highest nonzero decoded digit plus one. Declet encodings of the digits 8 and 9 are decoded correctly. For example, declet 10'h08C in the trailing field holds the digits 9,0,0.
- R12: A combination field 11xxy that is not special gives leading digit 8+y and biased-exponent MSBs xx. Any other combination field abc.. gives MSBs from bits 4:3 and leading digit from bits 2:0.
- R13: The match is the OR of all enabled mask-bit tests. A zero mask never matches, and a mask of 6'h3F matches every operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Classification request pulse |
| operand_i | input | OP_W | Operand in the packed decimal interchange encoding |
| mask_i | input | 6 | Data-group select mask |
| valid_o | output | 1 | Result valid pulse |
| result_o | output | 4 | Sign-qualified match code |
| fpcc_o | output | 4 | Floating-point condition code, a copy of the result |

## Verification
Zeros are applied at the middle exponent and at both extreme biased exponents, which separates the two zero groups. Coefficients whose highest nonzero digit comes from the declet 10'h08C sit at biased exponents on either side of the subnormal boundary. These tell subnormal from normal, and they expose a digit count that misreads the 8/9 encodings. Leading digits 0, 3, 8 and 9 under both combination-field layouts separate the short-normal group from the full-normal group and check the exponent MSB decode. Infinity, NaN, empty masks and full masks with both signs confirm the special group and each of the four code values.

// File: rtl/dfp_dg_pkg.sv
package dfp_dg_pkg;

  // one flag per data group; field order gives the mask bit position (5..0)
  typedef struct packed {
    logic zero_ord;
    logic zero_ext;
    logic sub_or_ext;
    logic norm_short;
    logic norm_full;
    logic special;
  } grp_t;

  function automatic int ecb_bits(input int w);
    return w / 16 + 4;
  endfunction

  function automatic int trail_bits(input int w);
    return w - 6 - ecb_bits(w);
  endfunction

  function automatic int n_declets(input int w);
    return trail_bits(w) / 10;
  endfunction

  function automatic int n_digits(input int w);
    return 3 * n_declets(w) + 1;
  endfunction

  function automatic int bexp_bits(input int w);
    return ecb_bits(w) + 2;
  endfunction

  function automatic int bexp_max(input int w);
    return 3 * (2 ** ecb_bits(w)) - 1;
  endfunction

endpackage

// File: rtl/dfp_declet_dec.sv
module dfp_declet_dec (
  input  logic [9:0] declet_i,
  output logic [3:0] dig_hi_o,
  output logic [3:0] dig_mid_o,
  output logic [3:0] dig_lo_o
);
  logic [9:0] d;
  assign d = declet_i;

  always_comb begin
    dig_hi_o  = {1'b0, d[9:7]};
    dig_mid_o = {1'b0, d[6:4]};
    dig_lo_o  = {1'b0, d[2:0]};
    if (d[3]) begin
      unique case (d[2:1])
        2'b00: dig_lo_o = {3'b100, d[0]};
        2'b01: begin
          dig_mid_o = {3'b100, d[4]};
          dig_lo_o  = {1'b0, d[6:5], d[0]};
        end
        2'b10: begin
          dig_hi_o = {3'b100, d[7]};
          dig_lo_o = {1'b0, d[9:8], d[0]};
        end
        default: begin
          unique case (d[6:5])
            2'b00: begin
              dig_hi_o  = {3'b100, d[7]};
              dig_mid_o = {3'b100, d[4]};
              dig_lo_o  = {1'b0, d[9:8], d[0]};
            end
            2'b01: begin
              dig_hi_o  = {3'b100, d[7]};
              dig_mid_o = {1'b0, d[9:8], d[4]};
              dig_lo_o  = {3'b100, d[0]};
            end
            2'b10: begin
              dig_mid_o = {3'b100, d[4]};
              dig_lo_o  = {3'b100, d[0]};
            end
            default: begin
              dig_hi_o  = {3'b100, d[7]};
              dig_mid_o = {3'b100, d[4]};
              dig_lo_o  = {3'b100, d[0]};
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/dfp_operand_unpack.sv
module dfp_operand_unpack #(
  parameter int OP_W = 64
) (
  input  logic [OP_W-1:0]                                  operand_i,
  output logic                                             special_o,
  output logic                                             coef_zero_o,
  output logic [dfp_dg_pkg::bexp_bits(OP_W)-1:0]           bexp_o,
  output logic [3:0]                                       lead_o,
  output logic [$clog2(dfp_dg_pkg::n_digits(OP_W)+1)-1:0]  digit_cnt_o
);
  localparam int ECB    = dfp_dg_pkg::ecb_bits(OP_W);
  localparam int TRAIL  = dfp_dg_pkg::trail_bits(OP_W);
  localparam int NDEC   = dfp_dg_pkg::n_declets(OP_W);
  localparam int NDIG   = dfp_dg_pkg::n_digits(OP_W);
  localparam int CNT_W  = $clog2(NDIG + 1);

  logic [4:0]       comb_f;
  logic [ECB-1:0]   cont_f;
  logic [TRAIL-1:0] trail_f;
  logic [1:0]       exp_msb;
  logic [3:0]       digits [NDIG];

  assign comb_f  = operand_i[OP_W-2 -: 5];
  assign cont_f  = operand_i[OP_W-7 -: ECB];
  assign trail_f = operand_i[TRAIL-1:0];

  assign special_o = (comb_f[4:1] == 4'b1111);

  // leading digit 8/9 moves the exponent MSBs down by two bits
  always_comb begin
    if (comb_f[4:3] == 2'b11) begin
      exp_msb = comb_f[2:1];
      lead_o  = {3'b100, comb_f[0]};
    end else begin
      exp_msb = comb_f[4:3];
      lead_o  = {1'b0, comb_f[2:0]};
    end
  end

  assign bexp_o = {exp_msb, cont_f};

  for (genvar g = 0; g < NDEC; g++) begin : g_declet
    dfp_declet_dec i_dec (
      .declet_i  (trail_f[10*g +: 10]),
      .dig_hi_o  (digits[3*g+2]),
      .dig_mid_o (digits[3*g+1]),
      .dig_lo_o  (digits[3*g])
    );
  end
  assign digits[NDIG-1] = lead_o;

  // no declet decodes to 000 except all-zero bits
  assign coef_zero_o = (trail_f == '0) && (lead_o == 4'd0);

  always_comb begin
    digit_cnt_o = '0;
    for (int i = 0; i < NDIG; i++) begin
      if (digits[i] != 4'd0) digit_cnt_o = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/dfp_group_classify.sv
module dfp_group_classify #(
  parameter int OP_W = 64
) (
  input  logic                                             special_i,
  input  logic                                             coef_zero_i,
  input  logic [dfp_dg_pkg::bexp_bits(OP_W)-1:0]           bexp_i,
  input  logic [3:0]                                       lead_i,
  input  logic [$clog2(dfp_dg_pkg::n_digits(OP_W)+1)-1:0]  digit_cnt_i,
  output dfp_dg_pkg::grp_t                                 grp_o
);
  localparam int BEXP_W = dfp_dg_pkg::bexp_bits(OP_W);
  localparam int NDIG   = dfp_dg_pkg::n_digits(OP_W);
  localparam logic [BEXP_W-1:0] BEXP_MAX = BEXP_W'(dfp_dg_pkg::bexp_max(OP_W));

  logic            extreme, finite, is_zero, is_sub, is_norm;
  logic [BEXP_W:0] adj_sum;

  assign extreme = (bexp_i == '0) || (bexp_i == BEXP_MAX);
  assign finite  = !special_i;
  assign is_zero = finite && coef_zero_i;

  // exp + digits - 1 < emin  <=>  biased exp + digits < NDIG
  assign adj_sum = {1'b0, bexp_i} + (BEXP_W+1)'(digit_cnt_i);
  assign is_sub  = finite && !coef_zero_i && (adj_sum < (BEXP_W+1)'(NDIG));
  assign is_norm = finite && !coef_zero_i && !is_sub;

  always_comb begin
    grp_o.zero_ord   = is_zero && !extreme;
    grp_o.zero_ext   = is_zero && extreme;
    grp_o.sub_or_ext = is_sub || (is_norm && extreme);
    grp_o.norm_short = is_norm && !extreme && (lead_i == 4'd0);
    grp_o.norm_full  = is_norm && !extreme && (lead_i != 4'd0);
    grp_o.special    = special_i;
  end
endmodule

// File: rtl/dfp_data_group_classifier.sv
module dfp_data_group_classifier #(
  parameter int OP_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] operand_i,
  input  logic [5:0]      mask_i,
  output logic            valid_o,
  output logic [3:0]      result_o,
  output logic [3:0]      fpcc_o
);
  localparam int BEXP_W = dfp_dg_pkg::bexp_bits(OP_W);
  localparam int NDIG   = dfp_dg_pkg::n_digits(OP_W);
  localparam int CNT_W  = $clog2(NDIG + 1);

  logic              special, coef_zero, match;
  logic [BEXP_W-1:0] bexp;
  logic [3:0]        lead;
  logic [CNT_W-1:0]  digit_cnt;
  dfp_dg_pkg::grp_t  grp;
  logic              valid_q;
  logic [3:0]        result_q;

  dfp_operand_unpack #(.OP_W(OP_W)) i_unpack (
    .operand_i   (operand_i),
    .special_o   (special),
    .coef_zero_o (coef_zero),
    .bexp_o      (bexp),
    .lead_o      (lead),
    .digit_cnt_o (digit_cnt)
  );

  dfp_group_classify #(.OP_W(OP_W)) i_classify (
    .special_i   (special),
    .coef_zero_i (coef_zero),
    .bexp_i      (bexp),
    .lead_i      (lead),
    .digit_cnt_i (digit_cnt),
    .grp_o       (grp)
  );

  assign match = |(grp & mask_i);

  // R1 reset clears code; R2 load only on request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= 4'b0000;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= {operand_i[OP_W-1], 1'b0, match, 1'b0};
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
  assign fpcc_o   = result_q;

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_sign_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (result_o[3] == $past(operand_i[OP_W-1])));
  p_one_group_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grp) == 1);
  p_special_field_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (operand_i[OP_W-2 -: 4] == 4'hF) |-> (grp.special && !grp.zero_ord && !grp.norm_full));
  p_zero_count_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_zero == (digit_cnt == '0));
  p_empty_mask_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == 6'd0) |=> !result_o[1]);
endmodule

// File: tb/test_dfp_data_group_classifier.sv
module test_dfp_data_group_classifier;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [5:0]  mask_i = '0;
  logic        valid_o;
  logic [3:0]  result_o;
  logic [3:0]  fpcc_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dfp_data_group_classifier #(.OP_W(64)) i_dfp_data_group_classifier (
    .clk_i, .rst_ni, .valid_i, .operand_i, .mask_i, .valid_o, .result_o, .fpcc_o
  );

  function automatic logic [63:0] enc(input bit s, input int bexp, input int lead,
                                      input logic [49:0] tail);
    logic [9:0] be;
    logic [3:0] ld;
    logic [4:0] g;
    be = 10'(bexp);
    ld = 4'(lead);
    if (lead < 8) g = {be[9:8], ld[2:0]};
    else          g = {2'b11, be[9:8], ld[0]};
    return {s, g, be[7:0], tail};
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  // one request, sampled at the falling edge after the loading edge
  task automatic apply(input string req, input logic [63:0] op, input logic [5:0] m,
                       input logic [3:0] exp);
    @(negedge clk_i);
    operand_i = op; mask_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid"}, {3'b0, valid_o}, 4'b0001);
    chk(req, result_o, exp);
    chk({req, " R4 fpcc"}, fpcc_o, exp);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 result", result_o, 4'b0000);
    chk("R1 fpcc", fpcc_o, 4'b0000);
    chk("R1 valid", {3'b0, valid_o}, 4'b0000);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero;
    apply("R5 zero mid", enc(0, 398, 0, '0), 6'h20, 4'b0010);
    apply("R5 R3 neg zero mid", enc(1, 398, 0, '0), 6'h20, 4'b1010);
    apply("R6 zero mid no ext", enc(0, 398, 0, '0), 6'h10, 4'b0000);
    apply("R3 neg nomatch", enc(1, 398, 0, '0), 6'h10, 4'b1000);
    apply("R6 zero emin", enc(0, 0, 0, '0), 6'h10, 4'b0010);
    apply("R5 zero emin no ord", enc(0, 0, 0, '0), 6'h20, 4'b0000);
    apply("R6 zero emax", enc(0, 767, 0, '0), 6'h10, 4'b0010);
  endtask

  task automatic t_subnormal;
    apply("R7 sub emin", enc(0, 0, 0, 50'd1), 6'h08, 4'b0010);
    apply("R8 sub not normal", enc(0, 0, 0, 50'd1), 6'h04, 4'b0000);
    apply("R7 sub mid", enc(0, 3, 0, 50'd1), 6'h08, 4'b0010);
    // declet 08C holds 9,0,0 -> highest digit index 11, count 12
    apply("R11 R7 below boundary", enc(0, 3, 0, {10'h000, 10'h08C, 30'd0}), 6'h08, 4'b0010);
    apply("R11 R8 below boundary", enc(0, 3, 0, {10'h000, 10'h08C, 30'd0}), 6'h04, 4'b0000);
    apply("R11 R8 at boundary", enc(0, 4, 0, {10'h000, 10'h08C, 30'd0}), 6'h04, 4'b0010);
    apply("R11 R7 at boundary", enc(0, 4, 0, {10'h000, 10'h08C, 30'd0}), 6'h08, 4'b0000);
    apply("R11 top declet", enc(0, 1, 0, {10'h08C, 40'd0}), 6'h04, 4'b0010);
  endtask

  task automatic t_normal;
    apply("R7 norm emin", enc(0, 0, 5, '0), 6'h08, 4'b0010);
    apply("R9 norm emin not full", enc(0, 0, 5, '0), 6'h02, 4'b0000);
    apply("R7 R3 neg norm emax", enc(1, 767, 1, '0), 6'h08, 4'b1010);
    apply("R12 lead9 emax", enc(0, 767, 9, '0), 6'h08, 4'b0010);
    apply("R12 lead9 emax not full", enc(0, 767, 9, '0), 6'h02, 4'b0000);
    apply("R9 R12 lead9", enc(0, 398, 9, '0), 6'h02, 4'b0010);
    apply("R8 lead9 not short", enc(0, 398, 9, '0), 6'h04, 4'b0000);
    apply("R9 lead3", enc(0, 500, 3, 50'h123), 6'h02, 4'b0010);
    apply("R9 R12 neg lead8", enc(1, 398, 8, '0), 6'h02, 4'b1010);
    apply("R8 short", enc(0, 398, 0, 50'd1), 6'h04, 4'b0010);
    apply("R9 short not full", enc(0, 398, 0, 50'd1), 6'h02, 4'b0000);
  endtask

  task automatic t_special;
    apply("R10 inf", {1'b0, 5'b11110, 58'h123}, 6'h01, 4'b0010);
    apply("R10 inf other bits", {1'b0, 5'b11110, 58'd0}, 6'h3E, 4'b0000);
    apply("R10 R3 neg nan", {1'b1, 5'b11111, 58'h3}, 6'h01, 4'b1010);
    apply("R10 R3 neg nan other", {1'b1, 5'b11111, 58'h3}, 6'h3E, 4'b1000);
  endtask

  task automatic t_mask;
    apply("R13 empty mask", enc(0, 398, 9, '0), 6'h00, 4'b0000);
    apply("R13 R3 empty neg", enc(1, 0, 0, '0), 6'h00, 4'b1000);
    apply("R13 full mask", enc(0, 398, 9, '0), 6'h3F, 4'b0010);
    apply("R13 full mask zero", enc(1, 0, 0, '0), 6'h3F, 4'b1010);
    apply("R13 pair mask", enc(0, 398, 0, 50'd1), 6'h06, 4'b0010);
  endtask

  task automatic t_hold;
    apply("R2 load", enc(1, 398, 9, '0), 6'h02, 4'b1010);
    @(negedge clk_i);
    chk("R2 valid drops", {3'b0, valid_o}, 4'b0000);
    operand_i = enc(0, 398, 0, '0); mask_i = 6'h00;
    repeat (3) @(negedge clk_i);
    chk("R2 hold", result_o, 4'b1010);
    chk("R2 R4 hold fpcc", fpcc_o, 4'b1010);
    chk("R2 still idle", {3'b0, valid_o}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_subnormal();
    t_normal();
    t_special();
    t_mask();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule